// File: doc/BRIEF.md
# Max-Log Forward State Metric Recursion Unit

This unit runs the forward half of a max-log soft-input soft-output trellis decoder for an eight-state recursive systematic constituent code. Each clock cycle that carries a valid step, it takes three signed soft values: the a-priori systematic value, the channel systematic value and the channel parity value. From these it forms the four branch metrics and advances all eight state metrics at once, with one add-compare-select element per state. The new metrics are normalised against state 0 and saturated to the metric width.

Every computed metric vector is also pushed onto an on-block last-in first-out stack. A backward recursion can then pop the vectors in reverse step order. At the first step of a window, the previous metrics come from one of three places instead of the running registers: a fixed block-start vector, a seed vector saved in the previous iteration, or an all-zero vector.

Top module: `fwd_metric_unit`

## Requirements
- R1: Branch metrics are formed per step as gamma(u=0,p=0)=0, gamma(0,1)=parity, gamma(1,0)=a-priori+systematic and gamma(1,1)=a-priori+systematic+parity, where u is the systematic bit and p the parity bit of the branch.
- R2: State index m packs the three shift-register bits as {s1,s2,s3} with s1 as the MSB. A transition on input u has feedback bit a=u^s2^s3, parity p=a^s1^s3 and next state {a,s1,s2}. Each new metric is the larger of its two incoming path sums (predecessor metric plus branch metric), with no correction term.
- R3: After each valid step, every new metric has the new state-0 metric subtracted from it and is then clamped to the signed W-bit range. State 0 therefore reads zero after every valid step.
- R4: On a valid step with win_start and blk_start high, the previous metrics are 0 for state 0 and -(2^(W-3)) for every other state.
- R5: On a valid step with win_start high, blk_start low and seed_valid high, the previous metrics are taken from seed_metrics. State n sits at bits [n*W +: W].
- R6: On a valid step with win_start high and both blk_start and seed_valid low, every previous metric is zero.
- R7: Without in_valid and pop, alpha_o, stk_top and the stack flags keep their values.
- R8: Each valid step pushes the new metric vector, which then appears at stk_top. Pops return the vectors in reverse push order.
- R9: stk_full rises once DEPTH vectors are held. A valid step while full still updates alpha_o but leaves the stack contents unchanged.
- R10: A pop while the stack is empty has no effect. A pop in the same cycle as in_valid is ignored, and the push still happens.
- R11: After reset, alpha_o is all zero, stk_empty is high, stk_full is low and stk_top is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One trellis step is presented this cycle |
| win_start | input | 1 | This step is the first of a window |
| blk_start | input | 1 | This window starts the code block |
| seed_valid | input | 1 | seed_metrics holds saved border metrics |
| seed_metrics | input | 8*W | Saved border metrics, state n at [n*W +: W] |
| la_in | input | SW | A-priori systematic soft value (signed) |
| ls_in | input | SW | Channel systematic soft value (signed) |
| lp_in | input | SW | Channel parity soft value (signed) |
| alpha_o | output | 8*W | Current normalised state metrics |
| pop | input | 1 | Remove the top vector from the stack |
| stk_top | output | 8*W | Vector at the top of the stack, zero when empty |
| stk_full | output | 1 | Stack holds DEPTH vectors |
| stk_empty | output | 1 | Stack holds no vectors |

## Verification
The bench builds the unit with 6-bit soft inputs, an 8-bit metric and a stack depth of 8. The narrow metric brings the saturation clamp within reach of ordinary input values, and the shallow stack makes fill, overflow and complete drain happen within a few steps. A grid of 216 soft-value triples is run through a continuous recursion, with window starts rotating through all three initialisation sources. An arithmetic trellis model that enumerates transitions forward predicts every vector.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
   localparam int NST = 8;

   // Source state of the k-th incoming branch of state n: {s1,s2,s3} shifts left
   function automatic logic [2:0] pred_state(input logic [2:0] n, input logic k);
      return {n[1], n[0], k};
   endfunction

   // {u,p} label of the k-th incoming branch of state n
   function automatic logic [1:0] branch_lbl(input logic [2:0] n, input logic k);
      logic a, s1, s2, s3, u, p;
      a  = n[2];
      s1 = n[1];
      s2 = n[0];
      s3 = k;
      u  = a ^ s2 ^ s3;
      p  = a ^ s1 ^ s3;
      return {u, p};
   endfunction
endpackage

// File: rtl/fwd_bmu.sv
`timescale 1ns/1ps
module fwd_bmu #(
   parameter int SW = 6,
   parameter int GW = SW + 2
) (
   input  logic signed [SW-1:0] la,
   input  logic signed [SW-1:0] ls,
   input  logic signed [SW-1:0] lp,
   output logic signed [GW-1:0] gam [4]
);
   logic signed [GW-1:0] sys_sum;

   assign sys_sum = GW'(la) + GW'(ls);
   assign gam[0]  = '0;
   assign gam[1]  = GW'(lp);
   assign gam[2]  = sys_sum;
   assign gam[3]  = sys_sum + GW'(lp);
endmodule

// File: rtl/fwd_acs.sv
`timescale 1ns/1ps
module fwd_acs #(
   parameter int W  = 10,
   parameter int GW = 8,
   parameter int RW = W + 2
) (
   input  logic signed [W-1:0]  m0,
   input  logic signed [W-1:0]  m1,
   input  logic signed [GW-1:0] g0,
   input  logic signed [GW-1:0] g1,
   output logic signed [RW-1:0] best
);
   logic signed [RW-1:0] c0, c1;

   assign c0   = RW'(m0) + RW'(g0);
   assign c1   = RW'(m1) + RW'(g1);
   assign best = (c1 > c0) ? c1 : c0;
endmodule

// File: rtl/fwd_lifo.sv
`timescale 1ns/1ps
module fwd_lifo #(
   parameter int WD    = 80,
   parameter int DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [WD-1:0] wdata,
   input  logic          pop,
   output logic [WD-1:0] top,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PW = $clog2(DEPTH + 1);

   logic [WD-1:0] mem [DEPTH];
   logic [PW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == PW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !push && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[AW'(cnt)] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (do_push) cnt <= cnt + PW'(1);
      else if (do_pop)  cnt <= cnt - PW'(1);
   end

   assign top = empty ? '0 : mem[AW'(cnt - PW'(1))];
endmodule

// File: rtl/fwd_metric_unit.sv
`timescale 1ns/1ps
module fwd_metric_unit #(
   parameter int SW    = 6,
   parameter int W     = 10,
   parameter int DEPTH = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic                           win_start,
   input  logic                           blk_start,
   input  logic                           seed_valid,
   input  logic [fwd_pkg::NST*W-1:0]      seed_metrics,
   input  logic signed [SW-1:0]           la_in,
   input  logic signed [SW-1:0]           ls_in,
   input  logic signed [SW-1:0]           lp_in,
   output logic [fwd_pkg::NST*W-1:0]      alpha_o,
   input  logic                           pop,
   output logic [fwd_pkg::NST*W-1:0]      stk_top,
   output logic                           stk_full,
   output logic                           stk_empty
);
   localparam int NS   = fwd_pkg::NST;
   localparam int GW   = SW + 2;
   localparam int RW   = W + 2;
   localparam int DW   = RW + 1;
   localparam int VW   = NS * W;
   localparam int NEGI = -(1 << (W - 3));
   localparam logic signed [W-1:0]  NEG = W'(NEGI);
   localparam logic signed [DW-1:0] HI  = DW'((1 << (W - 1)) - 1);
   localparam logic signed [DW-1:0] LO  = DW'(-(1 << (W - 1)));

   if (SW < 2) begin : g_bad_sw
      $error("fwd_metric_unit: SW must be at least 2");
   end
   if (W < SW + 2) begin : g_bad_w
      $error("fwd_metric_unit: W must exceed SW+1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("fwd_metric_unit: DEPTH must be at least 2");
   end

   logic signed [GW-1:0] gam   [4];
   logic signed [W-1:0]  alpha_q [NS];
   logic signed [W-1:0]  prev  [NS];
   logic signed [RW-1:0] raw   [NS];
   logic signed [W-1:0]  nxt   [NS];
   logic [VW-1:0]        nxt_flat;

   fwd_bmu #(.SW(SW), .GW(GW)) u_bmu (
      .la(la_in), .ls(ls_in), .lp(lp_in), .gam(gam)
   );

   // Recursion source: running registers, or one of three window seeds
   always_comb begin
      for (int n = 0; n < NS; n++) begin
         if (!win_start)      prev[n] = alpha_q[n];
         else if (blk_start)  prev[n] = (n == 0) ? '0 : NEG;
         else if (seed_valid) prev[n] = seed_metrics[n*W +: W];
         else                 prev[n] = '0;
      end
   end

   for (genvar n = 0; n < NS; n++) begin : g_state
      localparam logic [2:0] P0 = fwd_pkg::pred_state(3'(n), 1'b0);
      localparam logic [2:0] P1 = fwd_pkg::pred_state(3'(n), 1'b1);
      localparam logic [1:0] L0 = fwd_pkg::branch_lbl(3'(n), 1'b0);
      localparam logic [1:0] L1 = fwd_pkg::branch_lbl(3'(n), 1'b1);
      logic signed [DW-1:0] diff;

      fwd_acs #(.W(W), .GW(GW), .RW(RW)) u_acs (
         .m0(prev[P0]), .m1(prev[P1]),
         .g0(gam[L0]),  .g1(gam[L1]),
         .best(raw[n])
      );

      assign diff = DW'(raw[n]) - DW'(raw[0]);
      assign nxt[n] = (diff > HI) ? HI[W-1:0] :
                      (diff < LO) ? LO[W-1:0] : diff[W-1:0];
      assign nxt_flat[n*W +: W] = nxt[n];
      assign alpha_o[n*W +: W]  = alpha_q[n];

      always_ff @(posedge clk) begin
         if (!rst_n)        alpha_q[n] <= '0;
         else if (in_valid) alpha_q[n] <= nxt[n];
      end
   end

   fwd_lifo #(.WD(VW), .DEPTH(DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid), .wdata(nxt_flat),
      .pop(pop), .top(stk_top),
      .full(stk_full), .empty(stk_empty)
   );
endmodule

// File: rtl/fwd_metric_chk.sv
`timescale 1ns/1ps
module fwd_metric_chk #(
   parameter int W     = 10,
   parameter int DEPTH = 64
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      pop,
   input logic [fwd_pkg::NST*W-1:0] alpha_o,
   input logic [fwd_pkg::NST*W-1:0] stk_top,
   input logic                      stk_full,
   input logic                      stk_empty
);
   // R3: normalisation pins state 0 to zero after each valid step
   p_state0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (alpha_o[W-1:0] == '0));

   // R7: idle cycles change nothing visible
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !pop) |=> ($stable(alpha_o) && $stable(stk_top)
                               && $stable(stk_full) && $stable(stk_empty)));

   // R8: a valid step always leaves at least one vector stacked
   p_push_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !stk_empty);

   // R9: full stays full unless a real pop happens
   p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_full && !(pop && !in_valid)) |=> stk_full);

   // R9: full and empty are mutually exclusive
   p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(stk_full && stk_empty));

   // R10: popping an empty stack keeps it empty
   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_empty && !in_valid) |=> stk_empty);
endmodule

bind fwd_metric_unit fwd_metric_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_fwd_metric_unit.sv
`timescale 1ns/1ps
module sim_fwd_metric_unit;
   localparam int SW = 6, W = 8, DEPTH = 8, NS = 8, VW = NS * W;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, in_valid, win_start, blk_start, seed_valid, pop;
   logic [VW-1:0] seed_metrics, alpha_o, stk_top;
   logic signed [SW-1:0] la_in, ls_in, lp_in;
   logic stk_full, stk_empty;

   fwd_metric_unit #(.SW(SW), .W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_start(win_start),
      .blk_start(blk_start), .seed_valid(seed_valid), .seed_metrics(seed_metrics),
      .la_in(la_in), .ls_in(ls_in), .lp_in(lp_in), .alpha_o(alpha_o),
      .pop(pop), .stk_top(stk_top), .stk_full(stk_full), .stk_empty(stk_empty)
   );

   int ntest = 0, nfail = 0;
   bit done = 0;
   int mdl [NS];
   int seed_i [NS];
   logic [VW-1:0] smem [DEPTH];
   int scnt = 0;

   function automatic int sat(int v);
      int hi = (1 << (W - 1)) - 1;
      int lo = -(1 << (W - 1));
      return (v > hi) ? hi : (v < lo) ? lo : v;
   endfunction

   function automatic logic [VW-1:0] packv();
      logic [VW-1:0] v;
      for (int n = 0; n < NS; n++) v[n*W +: W] = W'(mdl[n]);
      return v;
   endfunction

   // Forward enumeration of every (state, input) transition
   task automatic advance(int la, int ls, int lp);
      int best [NS];
      for (int n = 0; n < NS; n++) best[n] = -1000000;
      for (int m = 0; m < NS; m++) begin
         for (int u = 0; u < 2; u++) begin
            int s1 = (m >> 2) & 1, s2 = (m >> 1) & 1, s3 = m & 1;
            int a  = u ^ s2 ^ s3;
            int p  = a ^ s1 ^ s3;
            int nx = (a << 2) | (s1 << 1) | s2;
            int g  = (u ? la + ls : 0) + (p ? lp : 0);
            if (mdl[m] + g > best[nx]) best[nx] = mdl[m] + g;
         end
      end
      for (int n = 0; n < NS; n++) mdl[n] = sat(best[n] - best[0]);
   endtask

   task automatic chk_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
      ntest++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(string tag, logic act, logic exp);
      ntest++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic step(int la, int ls, int lp, bit ws, bit bs, bit sv, bit pp, string tag);
      @(negedge clk);
      la_in = SW'(la); ls_in = SW'(ls); lp_in = SW'(lp);
      in_valid = 1'b1; win_start = ws; blk_start = bs; seed_valid = sv; pop = pp;
      @(posedge clk);
      #1;
      in_valid = 1'b0; win_start = 1'b0; blk_start = 1'b0; seed_valid = 1'b0; pop = 1'b0;
      if (ws)
         for (int n = 0; n < NS; n++)
            mdl[n] = bs ? ((n == 0) ? 0 : -(1 << (W - 3))) : (sv ? seed_i[n] : 0);
      advance(la, ls, lp);
      if (scnt < DEPTH) begin
         smem[scnt] = packv();
         scnt++;
      end
      chk_vec(tag, alpha_o, packv());
      chk_vec("R8 stack top after push", stk_top, smem[scnt-1]);
      chk_bit("R9 full flag", stk_full, scnt == DEPTH);
   endtask

   task automatic pop_one(string tag);
      @(negedge clk);
      pop = 1'b1;
      @(posedge clk);
      #1;
      pop = 1'b0;
      if (scnt > 0) scnt--;
      chk_bit({tag, " empty"}, stk_empty, scnt == 0);
      if (scnt > 0) chk_vec({tag, " order"}, stk_top, smem[scnt-1]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", ntest, nfail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      ntest++;
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int vals [6] = '{-32, -17, -5, 0, 9, 31};
      int i = 0;
      logic [VW-1:0] snap_a, snap_t;
      for (int n = 0; n < NS; n++) begin
         seed_i[n] = n * 7 - 20;
         seed_metrics[n*W +: W] = W'(seed_i[n]);
      end
      rst_n = 1'b0; in_valid = 1'b0; win_start = 1'b0; blk_start = 1'b0;
      seed_valid = 1'b0; pop = 1'b0; la_in = '0; ls_in = '0; lp_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk_vec("R11 alpha after reset", alpha_o, '0);
      chk_bit("R11 empty after reset", stk_empty, 1'b1);
      chk_bit("R11 full after reset", stk_full, 1'b0);
      chk_vec("R11 top after reset", stk_top, '0);
      for (int n = 0; n < NS; n++) mdl[n] = 0;

      // Grid sweep: R1 R2 R3 on every step, R4 R5 R6 at window starts, R9 on overflow
      for (int a = 0; a < 6; a++)
         for (int b = 0; b < 6; b++)
            for (int c = 0; c < 6; c++) begin
               bit ws = (i % 8 == 0);
               int src = (i / 8) % 3;
               string tag = !ws ? "R1 R2 R3 recursion" :
                            (src == 0) ? "R4 block-start seed" :
                            (src == 1) ? "R5 saved seed" : "R6 zero seed";
               step(vals[a], vals[b], vals[c], ws, ws && src == 0, ws && src == 1, 1'b0, tag);
               i++;
            end

      // Saturation corner under a block start (R3 with R4)
      step(-32, -32, -32, 1'b1, 1'b1, 1'b0, 1'b0, "R3 clamp block start");
      step(31, 31, -32, 1'b0, 1'b0, 1'b0, 1'b0, "R3 clamp continue");

      // R8: drain in reverse order
      for (int k = 0; k < DEPTH; k++) pop_one("R8 pop");

      // R10: pop on empty stack
      snap_a = alpha_o;
      pop_one("R10 pop on empty");
      chk_vec("R10 alpha unchanged by empty pop", alpha_o, snap_a);

      // R10: pop together with a step is ignored
      step(5, -3, 12, 1'b0, 1'b0, 1'b0, 1'b1, "R10 step with pop");
      chk_bit("R10 pop with push ignored", stk_empty, 1'b0);

      // R7: idle cycles
      snap_a = alpha_o;
      snap_t = stk_top;
      repeat (4) @(posedge clk);
      #1;
      chk_vec("R7 alpha held when idle", alpha_o, snap_a);
      chk_vec("R7 top held when idle", stk_top, snap_t);
      chk_bit("R7 empty held when idle", stk_empty, 1'b0);

      finish_run();
   end
endmodule